// File: doc/BRIEF.md
# Cascadable Parallel-Load Status Serializer

This block turns one snapshot of eight filtered input states plus three diagnostic flags (over-temperature, under-voltage and a parity bit) into an 11-bit serial stream. A host drives four slow external strobes: an active-low load, an active-low shift enable, a serial clock and a serial data input. The block reads the stream back on one serial output. The block runs on a fast system clock. It passes every external strobe through a two-flop synchronizer and finds rising serial-clock edges by comparing successive synchronized samples.

While the load strobe is low, the register keeps following the parallel inputs, and this overrides any shifting. Once load is high, the parallel inputs no longer reach the register. Each rising serial-clock edge that arrives while shift enable is low then moves the frame one place toward the output and takes in the serial input at the far end. Several instances can be chained by wiring one serial output to the next serial input. The host then sees a single long frame, and each section is 11 bits.

Top module: `status_chain_serializer`

## Requirements
- R1: While `ld_n` is low, the register copies the parallel inputs on every system clock, whatever `sclk`, `ce_n` and `sin` are doing. A serial-clock rise during load does not shift.
- R2: While `ld_n` is high, changes on `in_data`, `ot_flag`, `uv_flag` and `par_bit` do not reach the register.
- R3: A shift of exactly one position happens for each rising edge of `sclk` seen while `ld_n` is high and `ce_n` is low.
- R4: While `ld_n` is high and `ce_n` is high, rising `sclk` edges leave the frame unchanged.
- R5: Counting from the output end, the frame holds `in_data[7]`, `in_data[6]` and so on down to `in_data[0]`, followed by `ot_flag`, then `uv_flag`, with `par_bit` last.
- R6: After a load, `sout` shows `in_data[7]` without any `sclk` edge.
- R7: On each shift, `sin` enters the stage next to the parity bit. After 11 shifts, the first `sin` bit shifted in is at `sout`, so chained instances form one continuous stream.
- R8: After reset the frame is all zeros and `sout` is 0.
- R9: A falling edge of `sclk` never shifts the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_n | input | 1 | Active-low parallel load strobe (asynchronous) |
| ce_n | input | 1 | Active-low shift enable (asynchronous) |
| sclk | input | 1 | External serial clock (asynchronous) |
| sin | input | 1 | Serial input from an upstream instance |
| in_data | input | 8 | Debounced input states |
| ot_flag | input | 1 | Over-temperature diagnostic bit |
| uv_flag | input | 1 | Under-voltage diagnostic bit |
| par_bit | input | 1 | Parity diagnostic bit |
| sout | output | 1 | Serial output, the frame's output-end stage |

## Verification
Load and shift can both ask for the register in the same system cycle. This happens when a rising `sclk` edge is detected while `ld_n` is still low and `ce_n` is low. The bench provokes this by pulsing `sclk` during a held load while it changes the parallel word. It then releases load and reads the frame out. The frame passes only if it equals the last parallel word, with no bit lost to a shift. The sweep walks all 256 data patterns, with diagnostic bits derived from each one. For every pattern the bench reads the frame out and then shifts a second known word through to check how the chain passes data along.

// File: rtl/ser_pkg.sv
package ser_pkg;
  // Register operation chosen each system cycle
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } ser_op_t;

  // Slot of each external strobe in the synchronizer bus
  localparam int SY_LD   = 0;
  localparam int SY_CE   = 1;
  localparam int SY_CLK  = 2;
  localparam int SY_SIN  = 3;
  localparam int SY_NUM  = 4;

  // Idle level of each strobe, indexed as above: sin=0, sclk=0, ce_n=1, ld_n=1
  localparam logic [SY_NUM-1:0] SY_IDLE = 4'b0011;

  // Number of diagnostic bits appended behind the data
  localparam int DIAG_W = 3;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int               WIDTH   = 4,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/ser_edge.sv
module ser_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= level;
  end
  assign rise = level & ~prev;

  // R3: one detected rise per external edge, never two cycles in a row
  p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
  // R9: a falling level never produces a rise
  p_no_rise_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(level) |-> !rise);
endmodule

// File: rtl/ser_shreg.sv
module ser_shreg
  import ser_pkg::*;
#(
  parameter int DATA_W  = 8,
  localparam int FRAME_W = DATA_W + DIAG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_req,
  input  logic               shift_req,
  input  logic               ser_in,
  input  logic [DATA_W-1:0]  data,
  input  logic               ot,
  input  logic               uv,
  input  logic               par,
  output logic [FRAME_W-1:0] frame
);
  // Output end is the MSB: data MSB first, then ot, uv, par at bit 0.
  function automatic logic [FRAME_W-1:0] pack_frame(
    input logic [DATA_W-1:0] d, input logic t, input logic u, input logic p);
    return {d, t, u, p};
  endfunction

  function automatic logic [FRAME_W-1:0] shift_frame(
    input logic [FRAME_W-1:0] f, input logic s);
    return {f[FRAME_W-2:0], s};
  endfunction

  ser_op_t              op;
  logic [FRAME_W-1:0]   load_word;

  assign load_word = pack_frame(data, ot, uv, par);

  always_comb begin
    if (load_req)       op = OP_LOAD;
    else if (shift_req) op = OP_SHIFT;
    else                op = OP_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame <= '0;
    else begin
      case (op)
        OP_LOAD:  frame <= load_word;
        OP_SHIFT: frame <= shift_frame(frame, ser_in);
        default:  frame <= frame;
      endcase
    end
  end

  // R1: a load cycle leaves the packed parallel word in the register
  p_load_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> frame == $past(load_word));
  // R2, R4: no request means the frame is untouched
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_req && !shift_req) |=> $stable(frame));
  // R3: a shift moves every stage one place toward the output
  p_shift_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_req && shift_req) |=> frame[FRAME_W-1:1] == $past(frame[FRAME_W-2:0]));
  // R7: the serial input lands in the stage next to parity
  p_sin_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_req && shift_req) |=> frame[0] == $past(ser_in));
endmodule

// File: rtl/status_chain_serializer.sv
module status_chain_serializer
  import ser_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int FRAME_W    = DATA_W + DIAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_n,
  input  logic              ce_n,
  input  logic              sclk,
  input  logic              sin,
  input  logic [DATA_W-1:0] in_data,
  input  logic              ot_flag,
  input  logic              uv_flag,
  input  logic              par_bit,
  output logic              sout
);
  logic [SY_NUM-1:0]  raw_bus, sync_bus;
  logic               sclk_rise;
  logic               load_req, shift_req;
  logic [FRAME_W-1:0] frame;

  always_comb begin
    raw_bus         = '0;
    raw_bus[SY_LD]  = ld_n;
    raw_bus[SY_CE]  = ce_n;
    raw_bus[SY_CLK] = sclk;
    raw_bus[SY_SIN] = sin;
  end

  ser_sync #(.WIDTH(SY_NUM), .STAGES(SYNC_STAGES), .RST_VAL(SY_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus));

  ser_edge u_edge (
    .clk(clk), .rst_n(rst_n), .level(sync_bus[SY_CLK]), .rise(sclk_rise));

  // Named events for the assertions
  assign load_req  = ~sync_bus[SY_LD];
  assign shift_req = sclk_rise & ~sync_bus[SY_CE];

  ser_shreg #(.DATA_W(DATA_W)) u_reg (
    .clk(clk), .rst_n(rst_n),
    .load_req(load_req), .shift_req(shift_req), .ser_in(sync_bus[SY_SIN]),
    .data(in_data), .ot(ot_flag), .uv(uv_flag), .par(par_bit),
    .frame(frame));

  assign sout = frame[FRAME_W-1];

  // R6: the output end follows input MSB while loading
  p_msb_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> sout == $past(in_data[DATA_W-1]));
  // R3, R4: shift enable high blocks serial movement of the output
  p_ce_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_req && sync_bus[SY_CE]) |=> $stable(sout));
  // R8: reset state is all zeros
  p_reset_zero_r8: assert property (@(posedge clk)
    !rst_n |-> frame == '0);
endmodule

// File: tb/sim_status_chain_serializer.sv
module sim_status_chain_serializer;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int FW = DW + 3;
  localparam int SETTLE = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_n = 1'b1, ce_n = 1'b1, sclk = 1'b0, sin = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic ot_flag = 1'b0, uv_flag = 1'b0, par_bit = 1'b0;
  logic sout;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_chain_serializer u0 (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .ce_n(ce_n), .sclk(sclk),
    .sin(sin), .in_data(in_data), .ot_flag(ot_flag), .uv_flag(uv_flag),
    .par_bit(par_bit), .sout(sout));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected=<190000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected frame from R5: index FW-1 is the output end.
  function automatic logic [FW-1:0] expect_frame(
    input logic [DW-1:0] d, input logic t, input logic u, input logic p);
    logic [FW-1:0] f;
    for (int i = 0; i < DW; i++) f[FW-1-i] = d[DW-1-i];
    f[2] = t; f[1] = u; f[0] = p;
    return f;
  endfunction

  task automatic pulse();
    sclk = 1'b1; tick(SETTLE);
    sclk = 1'b0; tick(SETTLE);
  endtask

  task automatic set_par(input logic [DW-1:0] d, input logic t, input logic u, input logic p);
    in_data = d; ot_flag = t; uv_flag = u; par_bit = p;
  endtask

  task automatic do_load();
    ld_n = 1'b0; tick(SETTLE);
    ld_n = 1'b1; tick(SETTLE);
  endtask

  // Read FW bits (checking each before its shift) while feeding sin_word MSB first.
  task automatic readout(input logic [FW-1:0] exp, input logic [FW-1:0] sin_word, input string tag);
    ce_n = 1'b0;
    for (int i = 0; i < FW; i++) begin
      check(sout, exp[FW-1-i], tag);
      sin = sin_word[FW-1-i];
      pulse();
    end
    sin = 1'b0;
    ce_n = 1'b1;
    tick(SETTLE);
  endtask

  initial begin
    logic [FW-1:0] ef;
    logic [FW-1:0] sw;
    tick(3);
    // R8: reset state
    check(sout, 1'b0, "R8 sout in reset");
    rst_n = 1'b1; tick(SETTLE);
    check(sout, 1'b0, "R8 sout after reset");
    readout('0, '0, "R8 frame zero after reset");

    // Exhaustive sweep: R5, R6, R3, R7, R9
    for (int v = 0; v < 256; v++) begin
      logic [DW-1:0] d;
      d = v[DW-1:0];
      set_par(d, d[0] ^ d[3], d[1] ^ d[6], ^d);
      ef = expect_frame(d, d[0] ^ d[3], d[1] ^ d[6], ^d);
      sw = {3'(v), ~d};
      do_load();
      check(sout, d[DW-1], "R6 input msb on sout before any clock");
      readout(ef, sw, "R5 R3 R9 frame order one bit per rising edge");
      readout(sw, '0, "R7 serial input reaches sout after eleven shifts");
    end

    // R4: shift enable high blocks shifting
    set_par(8'hA5, 1'b1, 1'b0, 1'b1);
    ef = expect_frame(8'hA5, 1'b1, 1'b0, 1'b1);
    do_load();
    ce_n = 1'b1;
    sin = 1'b1;
    pulse(); pulse(); pulse();
    sin = 1'b0;
    check(sout, 1'b1, "R4 sout held with enable high");
    readout(ef, '0, "R4 frame intact after clocks with enable high");

    // R2: parallel changes while load high are ignored
    set_par(8'h3C, 1'b0, 1'b1, 1'b0);
    ef = expect_frame(8'h3C, 1'b0, 1'b1, 1'b0);
    do_load();
    set_par(8'hC3, 1'b1, 1'b0, 1'b1);
    tick(2 * SETTLE);
    readout(ef, '0, "R2 parallel inputs blocked while load high");

    // R1: load held low overrides concurrent shift edges and tracks inputs
    ld_n = 1'b0; ce_n = 1'b0;
    set_par(8'h11, 1'b0, 1'b0, 1'b0);
    tick(SETTLE);
    check(sout, 1'b0, "R1 tracking during load (msb 0)");
    set_par(8'h96, 1'b1, 1'b1, 1'b0);
    sin = 1'b1;
    pulse(); pulse();
    check(sout, 1'b1, "R1 tracking during load with clocks (msb 1)");
    set_par(8'h4E, 1'b0, 1'b1, 1'b1);
    pulse();
    sin = 1'b0;
    ce_n = 1'b1;
    ld_n = 1'b1; tick(SETTLE);
    ef = expect_frame(8'h4E, 1'b0, 1'b1, 1'b1);
    readout(ef, '0, "R1 load wins over simultaneous shift");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule